// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block takes byte writes from a processor bus into a cartridge address window and turns them into 5-bit configuration values. Each value arrives one bit per write, taken from bit 0 of the data byte, with the least significant bit first. The two top address bits pick which of four configuration registers the value is meant for. When the fifth bit of a value arrives, the value is stored in that register. In the same step the block raises a one-clock commit pulse together with the register index, so that neighbouring banking logic can recompute its mapping.

Two events throw away a value that is only partly built. The first is a write whose data bit 7 is set. The second is a write that targets a different register than the write before it. In both cases the partial value and the bit count return to zero. The block only collects and holds the values. Bank address generation and mirroring decode are done elsewhere.

Top module: `cfg_serial_loader`

## Requirements
- R1: After synchronous reset, register 0 holds 0x0C, registers 1 to 3 hold 0, and the commit pulse is low.
- R2: Bit 0 of five accepted writes forms the value least significant bit first: the first write gives value bit 0 and the fifth gives value bit 4.
- R3: Data bits 1 to 6 of an accepted write have no effect on the stored value.
- R4: On the fifth accepted write, the value is stored in the register whose index equals address bits 14:13. The other three registers keep their contents.
- R5: The commit pulse is high for exactly one clock, in the cycle after the clock edge that takes the fifth write, and commit_idx then carries that register's index. The pulse stays low after the first four writes.
- R6: A write with data bit 7 set clears the bit count and the partial value, and commits nothing. The next five ordinary writes then build a fresh value.
- R7: A write whose address bits 14:13 differ from those of the previous write, including a previous bit-7 write, first clears the count and the partial value. That write is then taken as bit 0 of a new value.
- R8: After a commit, the count and partial value are empty, so the following value does not inherit any bits from the previous one.
- R9: Cycles with the write strobe low change no register, raise no pulse, and keep a partial value intact.
- R10: Address bits 12:0 take no part in register selection or in sequence tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 15 | Write address inside the cartridge window |
| wr_data | input | 8 | Write data; bit 7 aborts, bit 0 is the serial bit |
| cfg_vals | output | 20 | The four 5-bit registers; register n is at bits 5n+4:5n |
| commit_pulse | output | 1 | One-clock pulse when a register has just been written |
| commit_idx | output | 2 | Index of the register just written, valid with commit_pulse |

## Verification
The bench builds the block with its default parameters: a 5-bit value, four registers, a 15-bit address with the selector on bits 14:13, the abort flag on data bit 7, and a control reset value of 0x0C. With five writes per value, the tests can reach the corner cases directly: an abort after the fourth bit, which would otherwise commit on the next write, and a switch of target just before a fifth write. Data bits 1 to 6 and the low address bits are driven with busy patterns, so a wrong bit select or a wrong selector slice changes the stored values.

// File: rtl/cfg_loader_pkg.sv
// Package: default geometry shared by the serial loader modules.
// Assumes: the register count is a power of two.
package cfg_loader_pkg;
    localparam int unsigned CFG_VAL_W     = 5;
    localparam int unsigned CFG_NUM_REGS  = 4;
    localparam int unsigned CFG_ADDR_W    = 15;
    localparam int unsigned CFG_DATA_W    = 8;
    localparam int unsigned CFG_ABORT_BIT = 7;

    // Action the collector takes on an accepted write.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_ABORT  = 2'd1,
        ACT_SHIFT  = 2'd2,
        ACT_COMMIT = 2'd3
    } collect_act_e;
endpackage

// File: rtl/cfg_shift_collector.sv
// Module: builds a value from bit 0 of successive writes, least significant
// bit first. A write with the abort bit set, or a write to a different
// target than the last one, empties the partial value.
// Assumes: wr_sel is only meaningful while wr_en is high.
module cfg_shift_collector
    import cfg_loader_pkg::*;
#(
    parameter int unsigned VAL_W     = CFG_VAL_W,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned DATA_W    = CFG_DATA_W,
    parameter int unsigned ABORT_BIT = CFG_ABORT_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit_en,
    output logic [SEL_W-1:0]  commit_sel,
    output logic [VAL_W-1:0]  commit_val
);
    localparam int unsigned CNT_W = (VAL_W > 1) ? $clog2(VAL_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(VAL_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [VAL_W-1:0] part_q;
    logic [SEL_W-1:0] last_sel_q;

    logic             restart;
    logic [CNT_W-1:0] base_cnt;
    logic [VAL_W-1:0] base_part;
    logic [VAL_W-1:0] next_part;
    collect_act_e     act;
    logic             unused_data;

    assign unused_data = ^wr_data;

    // Pick the starting point for this write and classify the action.
    always_comb begin
        restart   = (wr_sel != last_sel_q);
        base_cnt  = restart ? '0 : cnt_q;
        base_part = restart ? '0 : part_q;
        next_part = base_part | (VAL_W'(wr_data[0]) << base_cnt);
        if (!wr_en)
            act = ACT_IDLE;
        else if (wr_data[ABORT_BIT])
            act = ACT_ABORT;
        else if (base_cnt == LAST_CNT)
            act = ACT_COMMIT;
        else
            act = ACT_SHIFT;
    end

    assign commit_en  = (act == ACT_COMMIT);
    assign commit_sel = wr_sel;
    assign commit_val = next_part;

    // Track the bit count, the partial value and the last target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            part_q     <= '0;
            last_sel_q <= '0;
        end else begin
            if (wr_en)
                last_sel_q <= wr_sel;
            case (act)
                ACT_SHIFT: begin
                    cnt_q  <= base_cnt + CNT_W'(1);
                    part_q <= next_part;
                end
                ACT_ABORT, ACT_COMMIT: begin
                    cnt_q  <= '0;
                    part_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // R2: the count never passes the last bit position.
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // R6: an abort write leaves the collector empty.
    p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[ABORT_BIT]) |=> (cnt_q == '0 && part_q == '0));

    // R7: a change of target makes the write the first bit of a new value.
    p_switch_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[ABORT_BIT] && (wr_sel != last_sel_q) && (VAL_W > 1))
        |=> (cnt_q == CNT_W'(1)));

    // R9: idle cycles keep the partial state.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cnt_q) && $stable(part_q)));
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: holds the configuration registers. Register 0 resets to the
// control value and the others to zero. A register loads only when a
// commit names it.
// Assumes: NUM_REGS equals 2**SEL_W.
module cfg_reg_bank #(
    parameter int unsigned VAL_W     = 5,
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned SEL_W     = 2,
    parameter logic [VAL_W-1:0] CTRL_INIT = 5'h0C
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_en,
    input  logic [SEL_W-1:0]          commit_sel,
    input  logic [VAL_W-1:0]          commit_val,
    output logic [NUM_REGS*VAL_W-1:0] cfg_vals
);
    logic [VAL_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [VAL_W-1:0] INIT_V = (g == 0) ? CTRL_INIT : '0;

        // Load this register when a commit targets its index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= INIT_V;
            else if (commit_en && (commit_sel == SEL_W'(g)))
                regs_q[g] <= commit_val;
        end

        assign cfg_vals[g*VAL_W +: VAL_W] = regs_q[g];

        // R4: a register not named by a commit holds its value.
        p_hold_unselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(commit_en && (commit_sel == SEL_W'(g))) |=> $stable(regs_q[g]));
    end
endmodule

// File: rtl/cfg_serial_loader.sv
// Module: top of the serial configuration loader. It slices the target
// selector from the top address bits, feeds the collector, stores finished
// values in the register bank and registers the commit pulse with its index.
// Assumes: each write lasts exactly one clock with wr_en high.
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned VAL_W     = CFG_VAL_W,
    parameter int unsigned NUM_REGS  = CFG_NUM_REGS,
    parameter int unsigned ADDR_W    = CFG_ADDR_W,
    parameter int unsigned DATA_W    = CFG_DATA_W,
    parameter int unsigned ABORT_BIT = CFG_ABORT_BIT,
    parameter logic [VAL_W-1:0] CTRL_INIT = 5'h0C,
    localparam int unsigned SEL_W    = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_REGS*VAL_W-1:0] cfg_vals,
    output logic                      commit_pulse,
    output logic [SEL_W-1:0]          commit_idx
);
    logic [SEL_W-1:0] wr_sel;
    logic             col_commit;
    logic [SEL_W-1:0] col_sel;
    logic [VAL_W-1:0] col_val;
    logic             unused_addr;

    assign wr_sel      = wr_addr[ADDR_W-1 -: SEL_W];
    assign unused_addr = ^wr_addr;

    cfg_shift_collector #(
        .VAL_W     (VAL_W),
        .SEL_W     (SEL_W),
        .DATA_W    (DATA_W),
        .ABORT_BIT (ABORT_BIT)
    ) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .commit_en  (col_commit),
        .commit_sel (col_sel),
        .commit_val (col_val)
    );

    cfg_reg_bank #(
        .VAL_W     (VAL_W),
        .NUM_REGS  (NUM_REGS),
        .SEL_W     (SEL_W),
        .CTRL_INIT (CTRL_INIT)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_en  (col_commit),
        .commit_sel (col_sel),
        .commit_val (col_val),
        .cfg_vals   (cfg_vals)
    );

    // Register the commit notice so it lines up with the new register value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_pulse <= 1'b0;
            commit_idx   <= '0;
        end else begin
            commit_pulse <= col_commit;
            if (col_commit)
                commit_idx <= col_sel;
        end
    end

    // R5: the pulse never lasts two clocks.
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> !commit_pulse);

    // R9: no write, no commit.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !commit_pulse);

    // R6: an abort write never commits.
    p_abort_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[ABORT_BIT]) |=> !commit_pulse);
endmodule

// File: tb/cfg_serial_loader_bench.sv
`timescale 1ns/1ps
// Directed bench for the serial configuration loader.
module cfg_serial_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [19:0] cfg_vals;
    logic        commit_pulse;
    logic [1:0]  commit_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_serial_loader u_cfg_serial_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .cfg_vals     (cfg_vals),
        .commit_pulse (commit_pulse),
        .commit_idx   (commit_idx)
    );

    function automatic logic [4:0] rd(input int i);
        return cfg_vals[i*5 +: 5];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One write cycle; returns at the next falling edge with results settled.
    task automatic wr(input logic [1:0] sel, input logic [12:0] lo, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {sel, lo}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 15'h5A5A; wr_data = 8'hFF;
    endtask

    // Five writes that should commit v into register sel; checks each step.
    task automatic load(input logic [1:0] sel, input logic [4:0] v, input logic [7:0] fill, input string tag);
        for (int i = 0; i < 5; i++) begin
            wr(sel, 13'(i * 13'h0321), (fill & 8'h7E) | {7'b0, v[i]});
            if (i < 4) chk(commit_pulse == 1'b0, {tag, " no early pulse R5"}, commit_pulse, 0);
        end
        chk(commit_pulse == 1'b1, {tag, " pulse R5"}, commit_pulse, 1);
        chk(commit_idx == sel, {tag, " index R5"}, commit_idx, sel);
        chk(rd(sel) == v, {tag, " value R2 R4"}, rd(sel), v);
        @(negedge clk);
        chk(commit_pulse == 1'b0, {tag, " pulse one clock R5"}, commit_pulse, 0);
    endtask

    task automatic t_reset();
        chk(rd(0) == 5'h0C, "reset reg0 R1", rd(0), 5'h0C);
        chk(rd(1) == 0 && rd(2) == 0 && rd(3) == 0, "reset regs1-3 R1", cfg_vals[19:5], 0);
        chk(commit_pulse == 1'b0, "reset pulse R1", commit_pulse, 0);
    endtask

    task automatic t_basic();
        load(2'd3, 5'b10110, 8'h00, "basic reg3");
        chk(rd(0) == 5'h0C && rd(1) == 0 && rd(2) == 0, "others kept R4", cfg_vals[14:0], 15'h000C);
        load(2'd3, 5'b01001, 8'h00, "reload reg3 R8");
    endtask

    task automatic t_filler();
        load(2'd1, 5'h1F, 8'h7E, "fill reg1 R3");
        load(2'd2, 5'h01, 8'h7E, "fill reg2 R3");
        chk(rd(2) == 5'h01, "upper data bits ignored R3", rd(2), 1);
    endtask

    task automatic t_abort();
        for (int i = 0; i < 4; i++) wr(2'd2, 13'h0, 8'h01);
        wr(2'd2, 13'h0, 8'h80);
        chk(commit_pulse == 1'b0, "abort no pulse R6", commit_pulse, 0);
        wr(2'd2, 13'h0, 8'h00);
        chk(commit_pulse == 1'b0, "abort restarts count R6", commit_pulse, 0);
        chk(rd(2) == 5'h01, "abort reg kept R6", rd(2), 1);
        for (int i = 0; i < 3; i++) wr(2'd2, 13'h0, 8'h01);
        chk(commit_pulse == 1'b0, "abort count fresh R6", commit_pulse, 0);
        wr(2'd2, 13'h0, 8'h01);
        chk(commit_pulse == 1'b1 && rd(2) == 5'h1E, "abort then fresh value R6", rd(2), 5'h1E);
    endtask

    task automatic t_switch();
        for (int i = 0; i < 3; i++) wr(2'd0, 13'h0, 8'h01);
        wr(2'd3, 13'h0, 8'h00);
        wr(2'd3, 13'h0, 8'h00);
        chk(commit_pulse == 1'b0, "switch no commit at fifth overall R7", commit_pulse, 0);
        wr(2'd3, 13'h0, 8'h01);
        wr(2'd3, 13'h0, 8'h00);
        chk(commit_pulse == 1'b0, "switch still collecting R7", commit_pulse, 0);
        wr(2'd3, 13'h0, 8'h00);
        chk(commit_pulse == 1'b1 && commit_idx == 2'd3, "switch commit R7", commit_idx, 3);
        chk(rd(3) == 5'h04, "switch value R7", rd(3), 5'h04);
        chk(rd(0) == 5'h0C, "switch reg0 untouched R7", rd(0), 5'h0C);
        // An abort write to another target also moves the tracked target.
        for (int i = 0; i < 2; i++) wr(2'd1, 13'h0, 8'h01);
        wr(2'd2, 13'h0, 8'h80);
        for (int i = 0; i < 4; i++) wr(2'd1, 13'h0, 8'h00);
        chk(commit_pulse == 1'b0, "abort to other target restarts R7", commit_pulse, 0);
        wr(2'd1, 13'h0, 8'h00);
        chk(commit_pulse == 1'b1 && rd(1) == 5'h00, "value after target move R7", rd(1), 0);
    endtask

    task automatic t_idle();
        logic [19:0] snap;
        for (int i = 0; i < 4; i++) wr(2'd0, 13'h0, 8'h01);
        snap = cfg_vals;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            wr_addr = 15'(i * 15'h1357); wr_data = 8'(i * 8'h37);
            chk(commit_pulse == 1'b0, "idle no pulse R9", commit_pulse, 0);
        end
        chk(cfg_vals == snap, "idle regs held R9", cfg_vals, snap);
        wr(2'd0, 13'h0, 8'h00);
        chk(commit_pulse == 1'b1 && rd(0) == 5'h0F, "idle kept partial R9", rd(0), 5'h0F);
    endtask

    task automatic t_lowaddr();
        logic [12:0] lo [5] = '{13'h0000, 13'h1FFF, 13'h0123, 13'h1000, 13'h0AAA};
        for (int i = 0; i < 5; i++) wr(2'd2, lo[i], {7'b0, i[0]});
        chk(commit_pulse == 1'b1 && commit_idx == 2'd2, "low addr bits ignored R10", commit_idx, 2);
        chk(rd(2) == 5'h0A, "low addr value R10", rd(2), 5'h0A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_filler();
        t_abort();
        t_switch();
        t_idle();
        t_lowaddr();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule